// File: doc/BRIEF.md
# Dual Programmable Interval Timer

The block holds two identical down-counting timers and one interrupt unit behind a 32-bit register interface that takes whole-word accesses. Each timer has a reload register and a control register. The control register holds a two-bit operation code and a three-bit clock selector. The count clocks are not generated here. Four tick-enable inputs stand for the four selectable sources, and a timer in run mode counts one step for each cycle in which its chosen tick input is high.

When a timer expires it reloads itself from its reload register and sets its own bit in the raw interrupt register. Software can then:
- program a mask,
- clear raw bits by writing ones to an acknowledge location that holds no state,
- read the masked status.

The single level interrupt output is high while any masked bit is set. A free-running 32-bit cycle counter can also be read.

Register reads are combinational from the current state. Writes take effect at the clock edge on which `bus_wr` is sampled high.

Top module: `dual_interval_timer`

## Requirements
- R1: After reset the reload registers, counters, raw interrupt bits and mask are 0, both control registers read 0x1 (hold, no clock), the cycle counter reads 0 and `irq` is low.
- R2: A write to a reload register (offset 0x00 for timer 0, 0x10 for timer 1) only stores bits [31:0], which read back at the same offset. The counter is not changed.
- R3: A write to a control register (0x08 / 0x18) stores bits [4:0], which read back there. If the written operation bits [1:0] are 0, the counter takes the reload value at that same edge. A control write takes priority over counting and expiry of that timer in that cycle.
- R4: The counter (read at 0x04 / 0x14) changes only in run mode (operation 2). Clock selector bits [4:2] values 4 to 7 choose `tick_src[0]` to `tick_src[3]`. Values 0 to 3 give no ticks. Operation 1 (hold) and 3 (illegal, treated as hold) freeze the counter.
- R5: In run mode, a tick with the counter above 1 decrements it. A tick with the counter at 1 or 0 is an expiry: the counter reloads from the reload register, and raw interrupt bit 0 (timer 0) or bit 1 (timer 1) at offset 0x50 is set on that edge.
- R6: A write to 0x4C clears each raw interrupt bit that is 1 in bits [1:0] of the written value. It has no effect on later cycles. An expiry in the same cycle as the acknowledge of its bit leaves the bit set.
- R7: The mask at 0x48 stores bits [1:0]. Offset 0x54 reads raw AND mask. `irq` is high exactly when that value is non-zero.
- R8: Offset 0x38 reads a 32-bit counter that is 0 after reset, increments every cycle and wraps.
- R9: Reads of any other offset return 0. Writes to unmapped offsets and to the read-only offsets 0x04, 0x14, 0x38, 0x50 and 0x54 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_src | input | 4 | Tick enables of the four selectable count sources |
| bus_wr | input | 1 | Write strobe for one word |
| bus_addr | input | 8 | Byte offset of the accessed register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Level interrupt, high while any masked bit is set |

## Verification
Every stateful result is due one edge after its cause. Written registers, loads, decrements, expiries, raw-bit set and clear, and the `irq` level all settle on the edge that samples the write or tick. Read data follows `bus_addr` within the same cycle.

The bench drives inputs just after a rising edge and updates its reference model on each rising edge. It compares `bus_rdata` and `irq` against the model at the falling edge that follows, so every result is checked in the first cycle it is due. Directed sequences cover reset, load, the expiry period, acknowledge against a simultaneous expiry, and masking. A long random run covers the other offsets, operations and clock selections.

// File: rtl/dual_interval_timer.sv
module dual_interval_timer #(
  parameter int CW = 32,
  parameter int AW = 8,
  parameter int NSRC = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] tick_src,
  input  logic            bus_wr,
  input  logic [AW-1:0]   bus_addr,
  input  logic [31:0]     bus_wdata,
  output logic [31:0]     bus_rdata,
  output logic            irq
);
  localparam logic [AW-1:0] A_DIV    = AW'(8'h00);
  localparam logic [AW-1:0] A_CNT    = AW'(8'h04);
  localparam logic [AW-1:0] A_CTL    = AW'(8'h08);
  localparam logic [AW-1:0] A_STRIDE = AW'(8'h10);
  localparam logic [AW-1:0] A_TIME   = AW'(8'h38);
  localparam logic [AW-1:0] A_MASK   = AW'(8'h48);
  localparam logic [AW-1:0] A_ACK    = AW'(8'h4C);
  localparam logic [AW-1:0] A_RAW    = AW'(8'h50);
  localparam logic [AW-1:0] A_MSKD   = AW'(8'h54);
  localparam logic [1:0] OP_LOAD = 2'd0;
  localparam logic [1:0] OP_RUN  = 2'd2;

  logic [CW-1:0] div_q [2];
  logic [CW-1:0] cnt_q [2];
  logic [4:0]    ctl_q [2];
  logic [1:0]    raw_q, mask_q;
  logic [31:0]   time_q;

  logic [1:0] div_we, ctl_we, tick, running, expire;
  logic [1:0] ack_bits;

  always_comb begin
    for (int t = 0; t < 2; t++) begin
      div_we[t]  = bus_wr && bus_addr == A_DIV + AW'(t) * A_STRIDE;
      ctl_we[t]  = bus_wr && bus_addr == A_CTL + AW'(t) * A_STRIDE;
      tick[t]    = ctl_q[t][4] && tick_src[ctl_q[t][3:2]];
      running[t] = !ctl_we[t] && ctl_q[t][1:0] == OP_RUN && tick[t];
      expire[t]  = running[t] && cnt_q[t] <= CW'(1);
    end
  end

  assign ack_bits = (bus_wr && bus_addr == A_ACK) ? bus_wdata[1:0] : 2'b00;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int t = 0; t < 2; t++) begin
        div_q[t] <= '0;
        cnt_q[t] <= '0;
        ctl_q[t] <= 5'b00001;
      end
      raw_q  <= '0;
      mask_q <= '0;
      time_q <= '0;
    end else begin
      for (int t = 0; t < 2; t++) begin
        if (div_we[t]) div_q[t] <= bus_wdata[CW-1:0];
        if (ctl_we[t]) begin
          ctl_q[t] <= bus_wdata[4:0];
          if (bus_wdata[1:0] == OP_LOAD) cnt_q[t] <= div_q[t];
        end else if (expire[t]) begin
          cnt_q[t] <= div_q[t];
        end else if (running[t]) begin
          cnt_q[t] <= cnt_q[t] - CW'(1);
        end
      end
      raw_q  <= (raw_q & ~ack_bits) | expire;
      if (bus_wr && bus_addr == A_MASK) mask_q <= bus_wdata[1:0];
      time_q <= time_q + 32'd1;
    end
  end

  assign irq = |(raw_q & mask_q);

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_DIV:            bus_rdata = 32'(div_q[0]);
      A_CNT:            bus_rdata = 32'(cnt_q[0]);
      A_CTL:            bus_rdata = 32'(ctl_q[0]);
      A_DIV + A_STRIDE: bus_rdata = 32'(div_q[1]);
      A_CNT + A_STRIDE: bus_rdata = 32'(cnt_q[1]);
      A_CTL + A_STRIDE: bus_rdata = 32'(ctl_q[1]);
      A_TIME:           bus_rdata = time_q;
      A_MASK:           bus_rdata = 32'(mask_q);
      A_RAW:            bus_rdata = 32'(raw_q);
      A_MSKD:           bus_rdata = 32'(raw_q & mask_q);
      default:          bus_rdata = '0;
    endcase
  end

  AST_LOAD_TAKES_DIVIDER: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we[0] && bus_wdata[1:0] == OP_LOAD) |=> cnt_q[0] == $past(div_q[0])); // R3
  AST_HOLD_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_we[1] && ctl_q[1][1:0] != OP_RUN) |=> $stable(cnt_q[1])); // R4
  AST_EXPIRY_SETS_RAW: assert property (@(posedge clk) disable iff (!rst_n)
    expire[0] |=> raw_q[0]); // R5
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_bits[1] && !expire[1]) |=> !raw_q[1]); // R6
  AST_UNMASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == 2'b00) |-> !irq); // R7
  AST_TIME_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> time_q == $past(time_q) + 32'd1); // R8
endmodule

// File: tb/dual_interval_timer_bench.sv
module dual_interval_timer_bench;
  localparam int PERIOD = 10;

  logic        clk = 0, rst_n = 0, bus_wr = 0;
  logic [3:0]  tick_src = 0;
  logic [7:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic        irq;

  int checks = 0, failures = 0;

  dual_interval_timer u_dual_interval_timer (
    .clk(clk), .rst_n(rst_n), .tick_src(tick_src), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

  always #(PERIOD/2) clk = ~clk;

  bit [31:0] m_div [2], m_cnt [2], m_ctl [2];
  bit [1:0]  m_raw, m_mask;
  bit [31:0] m_time;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int t = 0; t < 2; t++) begin m_div[t] = 0; m_cnt[t] = 0; m_ctl[t] = 1; end
      m_raw = 0; m_mask = 0; m_time = 0;
    end else begin
      bit [1:0] ex;
      bit [1:0] ack;
      ex = 0;
      ack = (bus_wr && bus_addr == 8'h4C) ? bus_wdata[1:0] : 2'b00;
      for (int t = 0; t < 2; t++) begin
        int sel;
        bit tk, wrc;
        sel = (m_ctl[t] >> 2) & 7;
        tk  = (sel >= 4) ? tick_src[sel - 4] : 1'b0;
        wrc = bus_wr && bus_addr == 8'h08 + 8'(16 * t);
        if (wrc) begin
          if ((bus_wdata & 3) == 0) m_cnt[t] = m_div[t];
          m_ctl[t] = bus_wdata & 32'h1F;
        end else if ((m_ctl[t] & 3) == 2 && tk) begin
          if (m_cnt[t] <= 1) begin ex[t] = 1; m_cnt[t] = m_div[t]; end
          else m_cnt[t] = m_cnt[t] - 1;
        end
        if (bus_wr && bus_addr == 8'(16 * t)) m_div[t] = bus_wdata;
      end
      m_raw = (m_raw & ~ack) | ex;
      if (bus_wr && bus_addr == 8'h48) m_mask = bus_wdata[1:0];
      m_time = m_time + 1;
    end
  end

  function automatic bit [31:0] model_read(bit [7:0] a);
    case (a)
      8'h00: return m_div[0];
      8'h04: return m_cnt[0];
      8'h08: return m_ctl[0];
      8'h10: return m_div[1];
      8'h14: return m_cnt[1];
      8'h18: return m_ctl[1];
      8'h38: return m_time;
      8'h48: return 32'(m_mask);
      8'h50: return 32'(m_raw);
      8'h54: return 32'(m_raw & m_mask);
      default: return 0;
    endcase
  endfunction

  function automatic string tag_of(bit [7:0] a);
    case (a)
      8'h00, 8'h10: return "R2";
      8'h08, 8'h18: return "R3";
      8'h04, 8'h14: return "R4";
      8'h50:        return "R5";
      8'h38:        return "R8";
      8'h48, 8'h54: return "R7";
      default:      return "R9";
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk(tag_of(bus_addr), bus_rdata, model_read(bus_addr));
    chk("R7", 32'(irq), 32'(|(m_raw & m_mask)));
  end

  task automatic cyc(bit wr, bit [7:0] a, bit [31:0] d, bit [3:0] tk);
    @(posedge clk); #1;
    bus_wr = wr; bus_addr = a; bus_wdata = d; tick_src = tk;
  endtask

  task automatic rd(string tag, bit [7:0] a, bit [31:0] exp);
    cyc(0, a, 0, 0);
    @(negedge clk);
    chk(tag, bus_rdata, exp);
  endtask

  initial begin
    #(PERIOD * 200000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    bit [7:0] addrs [12];
    addrs = '{8'h00, 8'h04, 8'h08, 8'h10, 8'h14, 8'h18, 8'h38, 8'h48, 8'h4C, 8'h50, 8'h54, 8'h24};
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    rd("R1", 8'h50, 0);
    rd("R1", 8'h48, 0);
    rd("R1", 8'h08, 1);
    rd("R1", 8'h14, 0);
    chk("R1", 32'(irq), 0);
    // R2: divider write stores only
    cyc(1, 8'h00, 3, 0);
    rd("R2", 8'h00, 3);
    rd("R2", 8'h04, 0);
    // R3: load with source code 4
    cyc(1, 8'h08, 32'h10, 0);
    rd("R3", 8'h04, 3);
    // R5: run, three ticks expire and reload
    cyc(1, 8'h08, 32'h12, 0);
    cyc(0, 8'h04, 0, 4'b0001);
    cyc(0, 8'h04, 0, 4'b0001);
    rd("R5", 8'h04, 1);
    cyc(0, 8'h50, 0, 4'b0001);
    rd("R5", 8'h50, 1);
    rd("R5", 8'h04, 3);
    // R4: unselected source has no effect
    cyc(0, 8'h04, 0, 4'b1110);
    rd("R4", 8'h04, 3);
    // R7: masking
    chk("R7", 32'(irq), 0);
    cyc(1, 8'h48, 1, 0);
    rd("R7", 8'h54, 1);
    chk("R7", 32'(irq), 1);
    // R6: ack with simultaneous expiry keeps bit
    cyc(1, 8'h00, 1, 0);
    cyc(1, 8'h08, 32'h10, 0);
    cyc(1, 8'h08, 32'h12, 0);
    cyc(1, 8'h4C, 3, 4'b0001);
    rd("R6", 8'h50, 1);
    cyc(1, 8'h4C, 1, 0);
    rd("R6", 8'h50, 0);
    chk("R6", 32'(irq), 0);
    // R9: writes to read-only and unmapped offsets
    cyc(1, 8'h04, 32'hFF, 0);
    cyc(1, 8'h24, 32'hFF, 0);
    rd("R9", 8'h04, 1);
    rd("R9", 8'h24, 0);
    // random phase, compared every cycle against the model
    for (int i = 0; i < 4000; i++) begin
      bit [7:0] a;
      bit [31:0] d;
      a = addrs[$urandom_range(0, 11)];
      case (a)
        8'h00, 8'h10: d = $urandom_range(0, 6);
        8'h08, 8'h18: d = $urandom & 32'h1F;
        default:      d = $urandom;
      endcase
      cyc(($urandom_range(0, 3) == 0), a, d, 4'($urandom));
    end
    cyc(0, 0, 0, 0);
    @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule